// File: doc/BRIEF.md
# Single-Correct Double-Detect Codec for a 40-bit Control Word

This block guards a 40-bit control payload on its way across a noisy serial link, with no need for retransmission. The encoder path turns each payload into a 47-bit codeword. The codeword holds six Hamming check bits, placed at the power-of-two positions of a 63-position Hamming code, and one even-parity bit over the whole word. Positions 47 to 63 of that larger code are never used, so the code is a shortened one. Each path accepts one word per clock cycle and carries only a valid strobe, with no backpressure.

The decoder path works in two stages. The first stage computes the 6-bit syndrome and the overall parity of the received word. The second stage uses the syndrome to choose which payload bit to flip, and in the same stage it classifies the word as clean, corrected or uncorrectable. A receiver discards any word flagged as uncorrectable.

Top module: `secded_codec`

## Requirements
- R1: Codeword layout. Bit p (1..46) is Hamming position p. Payload bit i sits at the i-th position, counting upward, that is not a power of two (d0 at 3, d1 at 5, d2 at 6, d3 at 7, d4 at 9, ... d39 at 46). Check bit k at position 2^k (k = 0..5) is the XOR of the other positions 1..46 whose index has bit k set. Bit 0 makes the XOR of all 47 bits equal 0.
- R2: An encoder input accepted with `enc_in_valid` produces `enc_out_valid` and its codeword exactly 2 cycles later, with one word per cycle sustained.
- R3: A decoder input accepted with `dec_in_valid` produces `dec_out_valid` and its results exactly 2 cycles later, with one word per cycle sustained.
- R4: An error-free codeword returns its payload, and both flags are 0.
- R5: A codeword with any single bit in error, at any of positions 0..46, returns the original payload with `dec_out_corrected`=1 and `dec_out_uncorrectable`=0.
- R6: An error only in bit 0 leaves the payload unchanged and raises `dec_out_corrected`.
- R7: Any two bits in error give `dec_out_uncorrectable`=1 and `dec_out_corrected`=0. The payload output is unspecified in that case.
- R8: A syndrome in the range 47..63 together with odd overall parity points at a position removed by shortening. Such a word is reported uncorrectable, not corrected.
- R9: Both flags are 0 in every cycle where `dec_out_valid` is 0, and the two flags are never 1 together.
- R10: Synchronous active-low reset clears both output valids and both flags at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_in_valid | input | 1 | Payload strobe for the encoder |
| enc_in_data | input | 40 | Payload to encode |
| enc_out_valid | output | 1 | Codeword strobe |
| enc_out_word | output | 47 | Encoded codeword |
| dec_in_valid | input | 1 | Received-word strobe |
| dec_in_word | input | 47 | Received codeword |
| dec_out_valid | output | 1 | Decoder result strobe |
| dec_out_data | output | 40 | Recovered payload |
| dec_out_corrected | output | 1 | A single error was repaired |
| dec_out_uncorrectable | output | 1 | Word cannot be trusted |

## Verification
A wrong syndrome register or a wrong correction table shows up at the ports two cycles after the bad word enters. It appears as a flipped payload bit, a missing corrected flag, or a false uncorrectable flag, so the bench injects an error at every one of the 47 positions. A wrong check-bit mask in the encoder appears at once in the codeword, which the bench compares bit for bit against its own model. A lost or extra valid stage shows up as an output strobe one cycle early or late. Back-to-back streams show whether a word bleeds into its neighbour.

// File: rtl/secded_pkg.sv
// Shared sizes and constant helpers for the 40-bit SECDED codec.
// Assumes the parent Hamming code has 2**HAM_W - 1 positions and that the
// codeword uses positions 0..CW_W-1, with position 0 holding overall parity.
package secded_pkg;
    localparam int DATA_W   = 40;
    localparam int HAM_W    = 6;
    localparam int CW_W     = DATA_W + HAM_W + 1;
    localparam int LAST_POS = CW_W - 1;
    localparam int HALF_W   = DATA_W / 2;

    // True when p is a nonzero power of two (a check-bit position).
    function automatic bit is_check_pos(int p);
        return (p != 0) && ((p & (p - 1)) == 0);
    endfunction

    // Codeword position of payload bit idx.
    function automatic int data_pos(int idx);
        int cnt;
        cnt = 0;
        for (int p = 1; p <= LAST_POS; p++) begin
            if (!is_check_pos(p)) begin
                if (cnt == idx) return p;
                cnt++;
            end
        end
        return 0;
    endfunction

    // Positions covered by check bit k (bit k of the position index set).
    function automatic logic [CW_W-1:0] check_mask(int k);
        logic [CW_W-1:0] m;
        m = '0;
        for (int p = 1; p <= LAST_POS; p++) begin
            m[p] = ((p >> k) & 1) != 0;
        end
        return m;
    endfunction
endpackage

// File: rtl/secded_encoder.sv
// Two-stage SECDED encoder.
// Stage 1 places the payload into its codeword positions, forms the six
// Hamming check bits with XOR trees, and splits the wide overall parity into
// two partial XORs. Stage 2 inserts the check bits and folds the partials
// into bit 0. Assumes no backpressure.
module secded_encoder
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [CW_W-1:0]   out_word
);
    logic [CW_W-1:0]  placed;
    logic [HAM_W-1:0] ham;
    logic [CW_W-1:0]  s1_placed;
    logic [HAM_W-1:0] s1_ham;
    logic             s1_par_lo;
    logic             s1_par_hi;
    logic             s1_valid;
    logic [CW_W-1:0]  word_c;

    // Scatter payload bits into their non-power-of-two positions.
    always_comb begin
        placed = '0;
        for (int i = 0; i < DATA_W; i++) begin
            placed[data_pos(i)] = in_data[i];
        end
    end

    // One XOR tree per check bit over the positions it covers.
    for (genvar k = 0; k < HAM_W; k++) begin : g_ham
        localparam logic [CW_W-1:0] MASK = check_mask(k);
        assign ham[k] = ^(placed & MASK);
    end

    // Stage 1 registers: placed payload, check bits, partial parities.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_placed <= '0;
            s1_ham    <= '0;
            s1_par_lo <= 1'b0;
            s1_par_hi <= 1'b0;
        end else begin
            s1_valid  <= in_valid;
            s1_placed <= placed;
            s1_ham    <= ham;
            s1_par_lo <= ^in_data[HALF_W-1:0];
            s1_par_hi <= ^in_data[DATA_W-1:HALF_W];
        end
    end

    // Insert check bits and the folded overall parity.
    always_comb begin
        word_c = s1_placed;
        for (int k = 0; k < HAM_W; k++) begin
            word_c[1 << k] = s1_ham[k];
        end
        word_c[0] = s1_par_lo ^ s1_par_hi ^ (^s1_ham);
    end

    // Stage 2 output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= s1_valid;
            out_word  <= word_c;
        end
    end

    assert_enc_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (s1_valid == $past(in_valid)));
    assert_enc_even_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (^out_word == 1'b0));
endmodule

// File: rtl/secded_syndrome.sv
// Decoder stage 1: computes the 6-bit syndrome and the overall parity of the
// received word, and gathers the payload bits. Assumes no backpressure.
module secded_syndrome
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CW_W-1:0]   in_word,
    output logic              s1_valid,
    output logic [HAM_W-1:0]  s1_syn,
    output logic              s1_par_err,
    output logic [DATA_W-1:0] s1_data
);
    logic [HAM_W-1:0]  syn_c;
    logic [DATA_W-1:0] data_c;

    // Syndrome bit k re-checks every position with bit k of its index set.
    for (genvar k = 0; k < HAM_W; k++) begin : g_syn
        localparam logic [CW_W-1:0] MASK = check_mask(k);
        assign syn_c[k] = ^(in_word & MASK);
    end

    // Gather payload bits back out of the codeword.
    for (genvar i = 0; i < DATA_W; i++) begin : g_gather
        localparam int POS = data_pos(i);
        assign data_c[i] = in_word[POS];
    end

    // Stage 1 registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid   <= 1'b0;
            s1_syn     <= '0;
            s1_par_err <= 1'b0;
            s1_data    <= '0;
        end else begin
            s1_valid   <= in_valid;
            s1_syn     <= syn_c;
            s1_par_err <= ^in_word;
            s1_data    <= data_c;
        end
    end

    assert_dec_stage_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (s1_valid == $past(in_valid)));
endmodule

// File: rtl/secded_corrector.sv
// Decoder stage 2: a syndrome-indexed table picks the payload bit to flip.
// In parallel, the parity result classifies the word as clean, corrected or
// uncorrectable. Syndromes beyond the last used position are uncorrectable.
module secded_corrector
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_valid,
    input  logic [HAM_W-1:0]  s1_syn,
    input  logic              s1_par_err,
    input  logic [DATA_W-1:0] s1_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_corrected,
    output logic              out_uncorrectable
);
    localparam logic [HAM_W-1:0] LAST_SYN = HAM_W'(LAST_POS);

    logic [DATA_W-1:0] flip;
    logic              in_range;
    logic              corr_c;
    logic              unc_c;

    // Correction table: one-hot flip mask decoded from the syndrome.
    for (genvar i = 0; i < DATA_W; i++) begin : g_flip
        localparam logic [HAM_W-1:0] POS = HAM_W'(data_pos(i));
        assign flip[i] = (s1_syn == POS);
    end

    // Classify the word from its syndrome and parity mismatch.
    always_comb begin
        in_range = (s1_syn <= LAST_SYN);
        corr_c   = s1_par_err && in_range;
        unc_c    = (!s1_par_err && (s1_syn != '0)) || (s1_par_err && !in_range);
    end

    // Stage 2 output registers; flags only accompany a valid word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid         <= 1'b0;
            out_data          <= '0;
            out_corrected     <= 1'b0;
            out_uncorrectable <= 1'b0;
        end else begin
            out_valid         <= s1_valid;
            out_data          <= s1_data ^ (flip & {DATA_W{corr_c}});
            out_corrected     <= s1_valid && corr_c;
            out_uncorrectable <= s1_valid && unc_c;
        end
    end

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_corrected && out_uncorrectable));
    assert_flags_need_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_corrected && !out_uncorrectable));
    assert_out_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(s1_valid)));
endmodule

// File: rtl/secded_codec.sv
// Top level: an independent SECDED encoder path and decoder path, each
// a two-cycle pipeline taking one word per cycle with a valid strobe.
module secded_codec
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_in_valid,
    input  logic [DATA_W-1:0] enc_in_data,
    output logic              enc_out_valid,
    output logic [CW_W-1:0]   enc_out_word,
    input  logic              dec_in_valid,
    input  logic [CW_W-1:0]   dec_in_word,
    output logic              dec_out_valid,
    output logic [DATA_W-1:0] dec_out_data,
    output logic              dec_out_corrected,
    output logic              dec_out_uncorrectable
);
    logic              s1_valid;
    logic [HAM_W-1:0]  s1_syn;
    logic              s1_par_err;
    logic [DATA_W-1:0] s1_data;

    secded_encoder u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (enc_in_valid),
        .in_data   (enc_in_data),
        .out_valid (enc_out_valid),
        .out_word  (enc_out_word)
    );

    secded_syndrome u_syn (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (dec_in_valid),
        .in_word    (dec_in_word),
        .s1_valid   (s1_valid),
        .s1_syn     (s1_syn),
        .s1_par_err (s1_par_err),
        .s1_data    (s1_data)
    );

    secded_corrector u_cor (
        .clk               (clk),
        .rst_n             (rst_n),
        .s1_valid          (s1_valid),
        .s1_syn            (s1_syn),
        .s1_par_err        (s1_par_err),
        .s1_data           (s1_data),
        .out_valid         (dec_out_valid),
        .out_data          (dec_out_data),
        .out_corrected     (dec_out_corrected),
        .out_uncorrectable (dec_out_uncorrectable)
    );
endmodule

// File: tb/sim_secded_codec.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for every single-error position, streaming and reset.
module sim_secded_codec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_in_valid = 1'b0;
    logic [39:0] enc_in_data = '0;
    logic        enc_out_valid;
    logic [46:0] enc_out_word;
    logic        dec_in_valid = 1'b0;
    logic [46:0] dec_in_word = '0;
    logic        dec_out_valid;
    logic [39:0] dec_out_data;
    logic        dec_out_corrected;
    logic        dec_out_uncorrectable;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    secded_codec u0 (
        .clk(clk), .rst_n(rst_n),
        .enc_in_valid(enc_in_valid), .enc_in_data(enc_in_data),
        .enc_out_valid(enc_out_valid), .enc_out_word(enc_out_word),
        .dec_in_valid(dec_in_valid), .dec_in_word(dec_in_word),
        .dec_out_valid(dec_out_valid), .dec_out_data(dec_out_data),
        .dec_out_corrected(dec_out_corrected),
        .dec_out_uncorrectable(dec_out_uncorrectable)
    );

    // Vector: payload, error mask over 47 bits, expect corrected, expect uncorrectable.
    localparam int NV = 12;
    localparam logic [88:0] VEC [NV] = '{
        {40'h00_0000_0000, 47'h0,              1'b0, 1'b0},  // R4
        {40'hFF_FFFF_FFFF, 47'h0,              1'b0, 1'b0},  // R4
        {40'hA5_A5A5_A5A5, 47'h8,              1'b1, 1'b0},  // R5 d0
        {40'h01_2345_6789, 47'h4000_0000_0000, 1'b1, 1'b0},  // R5 d39
        {40'hFF_FF00_FF00, 47'h1,              1'b1, 1'b0},  // R6
        {40'h3C_0F0F_1234, 47'h1_0000_0000,    1'b1, 1'b0},  // R5 check pos 32
        {40'h5A_5A5A_5A5A, 47'h220,            1'b0, 1'b1},  // R7
        {40'h12_3456_789A, 47'h2_0001,         1'b0, 1'b1},  // R7 with bit 0
        {40'hDE_ADBE_EF01, 47'h1_0000_8001,    1'b0, 1'b1},  // R8 syndrome 47
        {40'h80_0000_0001, 47'h1_8000_0001,    1'b0, 1'b1},  // R8 syndrome 63
        {40'h0F_F0F0_0F0F, 47'h2,              1'b1, 1'b0},  // R5 check pos 1
        {40'h77_7777_7777, 47'h6,              1'b0, 1'b1}   // R7
    };

    // Reference encoder written from R1.
    function automatic logic [46:0] ref_enc(logic [39:0] d);
        logic [46:0] w;
        logic [5:0]  acc;
        int          idx;
        w = '0; acc = '0; idx = 0;
        for (int p = 1; p < 47; p++) begin
            if ((p & (p - 1)) != 0) begin
                w[p] = d[idx];
                if (d[idx]) acc ^= 6'(p);
                idx++;
            end
        end
        for (int k = 0; k < 6; k++) w[1 << k] = acc[k];
        w[0] = ^w;
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Encode one payload through the DUT and check timing and codeword.
    task automatic enc_one(input logic [39:0] d, input string req);
        @(negedge clk); enc_in_valid = 1'b1; enc_in_data = d;
        @(negedge clk); enc_in_valid = 1'b0;
        chk(enc_out_valid == 1'b0, "R2 early valid", 64'(enc_out_valid), 64'd0);
        @(negedge clk);
        chk(enc_out_valid == 1'b1, "R2 valid", 64'(enc_out_valid), 64'd1);
        chk(enc_out_word == ref_enc(d), req, 64'(enc_out_word), 64'(ref_enc(d)));
    endtask

    // Decode one word and check results after two cycles.
    task automatic dec_one(input logic [39:0] d, input logic [46:0] err,
                           input bit ec, input bit eu, input string req);
        @(negedge clk); dec_in_valid = 1'b1; dec_in_word = ref_enc(d) ^ err;
        @(negedge clk); dec_in_valid = 1'b0;
        chk(dec_out_valid == 1'b0, "R3 early valid", 64'(dec_out_valid), 64'd0);
        @(negedge clk);
        chk(dec_out_valid == 1'b1, "R3 valid", 64'(dec_out_valid), 64'd1);
        chk(dec_out_corrected == ec, {req, " corrected flag"}, 64'(dec_out_corrected), 64'(ec));
        chk(dec_out_uncorrectable == eu, {req, " uncorrectable flag"}, 64'(dec_out_uncorrectable), 64'(eu));
        if (!eu) chk(dec_out_data == d, {req, " payload"}, 64'(dec_out_data), 64'(d));
        @(negedge clk);
        chk(!dec_out_valid && !dec_out_corrected && !dec_out_uncorrectable,
            "R9 flags idle", {61'd0, dec_out_valid, dec_out_corrected, dec_out_uncorrectable}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!enc_out_valid && !dec_out_valid && !dec_out_corrected && !dec_out_uncorrectable,
            "R10 reset state", {60'd0, enc_out_valid, dec_out_valid, dec_out_corrected, dec_out_uncorrectable}, 64'd0);
        rst_n = 1'b1;

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            enc_one(VEC[v][88:49], "R1 codeword");
            dec_one(VEC[v][88:49], VEC[v][48:2], VEC[v][1], VEC[v][0], "R4-R8 vector");
        end

        // R5: single error at every position; R6 covered by position 0.
        for (int p = 0; p < 47; p++) begin
            dec_one(40'hC3_5A96_E10F, 47'(1) << p, 1'b1, 1'b0, "R5 single error");
        end

        // R2: back-to-back encoder stream.
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk(enc_out_valid == 1'b1, "R2 stream valid", 64'(enc_out_valid), 64'd1);
                chk(enc_out_word == ref_enc(40'h11_1111_1111 * 40'(i - 1)), "R2 stream word",
                    64'(enc_out_word), 64'(ref_enc(40'h11_1111_1111 * 40'(i - 1))));
            end
            enc_in_valid = (i < 4);
            enc_in_data  = 40'h11_1111_1111 * 40'(i + 1);
        end
        enc_in_valid = 1'b0;

        // R3: back-to-back decoder stream mixing clean, single and double errors.
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk(dec_out_valid == 1'b1, "R3 stream valid", 64'(dec_out_valid), 64'd1);
                chk(dec_out_corrected == ((i - 2) % 3 == 1), "R3 stream corrected",
                    64'(dec_out_corrected), 64'((i - 2) % 3 == 1));
                chk(dec_out_uncorrectable == ((i - 2) % 3 == 2), "R3 stream uncorrectable",
                    64'(dec_out_uncorrectable), 64'((i - 2) % 3 == 2));
                if ((i - 2) % 3 != 2)
                    chk(dec_out_data == 40'h0A_0B0C_0D00 + 40'(i - 2), "R3 stream payload",
                        64'(dec_out_data), 64'(40'h0A_0B0C_0D00 + 40'(i - 2)));
            end
            dec_in_valid = (i < 4);
            dec_in_word  = ref_enc(40'h0A_0B0C_0D00 + 40'(i)) ^
                           ((i % 3 == 1) ? 47'h400 : (i % 3 == 2) ? 47'h180 : 47'h0);
        end
        dec_in_valid = 1'b0;

        // R10: reset during traffic clears valids and flags at the next edge.
        @(negedge clk);
        enc_in_valid = 1'b1; dec_in_valid = 1'b1; dec_in_word = ref_enc(40'h5) ^ 47'h1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!enc_out_valid && !dec_out_valid && !dec_out_corrected && !dec_out_uncorrectable,
            "R10 reset mid-stream", {60'd0, enc_out_valid, dec_out_valid, dec_out_corrected, dec_out_uncorrectable}, 64'd0);
        enc_in_valid = 1'b0; dec_in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        dec_one(40'h99_8877_6655, 47'h800, 1'b1, 1'b0, "R10 after reset");

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule